// File: doc/BRIEF.md
# Channel Attention Mailbox Controller

This block is the host-facing front end of a two-channel I/O coprocessor. The host places a control block for a channel in shared memory. It then drives a channel-select input and pulls an active-low attention strobe. On the falling edge of the strobe the controller captures the select value. It fetches that channel's control block (command word and parameter-block pointer) over a word-wide request/acknowledge memory port. It then marks the channel busy by writing 0xFF to the channel's flag byte, reads the program start address from the parameter block, and pulses a start signal to the channel engine. The start address is one word for I/O-space programs and two words for system-space programs.

When the engine reports completion or a halt, the controller writes 0x00 to the flag byte. If the command word asked for it, the controller then raises that channel's interrupt, which stays up until the host acknowledges it. The two channels have their own registers and can run at the same time. A single sequencer serves their memory traffic in a fixed order. The control block of channel `c` sits at `CB_BASE + c*CB_STRIDE`, with the command word at offset +0, the pointer low word at +2, the pointer high word at +4, and the busy flag as the low byte of the word at +6.

Top module: `chan_attn_ctrl`

## Requirements
- R1: While reset is high and after it is released, `mem_req_o`, `eng_start_o`, `irq_o` and `err_o` are all zero until an attention strobe or a finish input arrives.
- R2: A high-to-low transition of `attn_n_i` selects channel `sel_i` (sampled in that cycle). For an idle channel, the first three accesses are reads of the command word, the pointer low word and the pointer high word, at control-block offsets +0, +2 and +4, in that order.
- R3: Right after the control-block reads, the block writes the busy flag with 0xFF: address offset +6, `mem_be_o` = 01 (low byte only), `mem_wdata_o` = 0x00FF. This happens before any parameter-block access or start pulse.
- R4: Command bit 6 selects the address space. When it is 1 (I/O), one read at the parameter-block address gives the start address `{4'h0, word}`. When it is 0 (system), reads at the pointer and at pointer+2 give `{word1[3:0], word0}`. The pointer is `{high[3:0], low}`.
- R5: After the start-address fetch, `eng_start_o[c]` pulses for exactly one cycle. At that point `eng_cmd_o[c]` holds command bits 2:0, and the channel's program and parameter-block addresses are on its engine outputs.
- R6: Command bits 5:4 are latched per channel and presented on `eng_prio_o[c]`.
- R7: A `done_i[c]` or `halt_i[c]` pulse while channel `c` runs causes a write of 0x00 to that channel's busy-flag byte (`mem_wdata_o` = 0x0000, `mem_be_o` = 01).
- R8: If command bit 3 is 1, `irq_o[c]` rises in the cycle after the clear write is acknowledged, never earlier. It stays high until `irq_ack_i[c]` is high at a clock edge and is low one clock later. If bit 3 is 0, no interrupt is raised.
- R9: An attention for a channel that is busy (from its accepted attention until its clear write is acknowledged) causes no memory access and sets `err_o[c]`. `err_o[c]` stays set until reset.
- R10: Only one memory access is outstanding. While `mem_req_o` is high without `mem_ack_i`, the address, write enable and write data stay unchanged.
- R11: Pending work is served in fixed order: busy-flag clears before new attentions, and channel 0 before channel 1. A pending attention for the other channel is served after the current sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_n_i | input | 1 | Host attention strobe, active low |
| sel_i | input | 1 | Channel select, sampled on the strobe's falling edge |
| done_i | input | 2 | Per-channel completion pulse from the engine |
| halt_i | input | 2 | Per-channel halt pulse from the engine |
| irq_ack_i | input | 2 | Per-channel interrupt acknowledge |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_be_o | output | 2 | Byte enables |
| mem_addr_o | output | 20 | Byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Access completes in this cycle |
| mem_rdata_i | input | 16 | Read data, valid with the acknowledge |
| eng_start_o | output | 2 | Per-channel start pulse |
| eng_cmd_o | output | 2x3 | Per-channel command code |
| eng_prio_o | output | 2x2 | Per-channel priority setting |
| eng_pb_addr_o | output | 2x20 | Per-channel parameter-block address |
| eng_prog_addr_o | output | 2x20 | Per-channel program start address |
| irq_o | output | 2 | Per-channel interrupt |
| err_o | output | 2 | Per-channel sticky busy-violation flag |

## Verification
The assertions check, on every cycle, the memory-port rules and the interrupt and start rules:
- a pending request holds its address and data;
- every write targets only the low byte with a flag value of 0xFF or 0x00;
- an interrupt rises only right after an acknowledged clear write to that channel's flag address;
- an interrupt persists until acknowledged and drops after the acknowledge;
- start pulses last one cycle, one channel at a time.

Only the directed scenarios can show the following:
- the exact access order for each address space;
- the assembled start and pointer addresses;
- the silence of the port on a busy-channel attention;
- the service order when both channels have work pending.

// File: rtl/chan_attn_pkg.sv
package chan_attn_pkg;

    localparam int NCH    = 2;
    localparam int AW     = 20;
    localparam int DW     = 16;
    localparam int CODE_W = 3;
    localparam int PRIO_W = 2;
    localparam int HI_W   = AW - DW;

    localparam logic [AW-1:0] OFS_CMD   = AW'(0);
    localparam logic [AW-1:0] OFS_PBL   = AW'(2);
    localparam logic [AW-1:0] OFS_PBH   = AW'(4);
    localparam logic [AW-1:0] OFS_FLAG  = AW'(6);
    localparam logic [AW-1:0] WORD_STEP = AW'(2);

    localparam logic [7:0] FLAG_SET = 8'hFF;
    localparam logic [7:0] FLAG_CLR = 8'h00;

    localparam logic [1:0] BE_LOW  = 2'b01;
    localparam logic [1:0] BE_WORD = 2'b11;

    typedef struct packed {
        logic              space_io;
        logic [PRIO_W-1:0] prio;
        logic              ie;
        logic [CODE_W-1:0] code;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_PBL,
        S_PBH,
        S_SET,
        S_PA0,
        S_PA1,
        S_GO,
        S_CLR
    } seq_t;

    function automatic logic [AW-1:0] chan_base(
        input logic [AW-1:0] base,
        input logic [AW-1:0] stride,
        input logic          ch
    );
        return ch ? (base + stride) : base;
    endfunction

    function automatic logic [DW-1:0] flag_word(input logic set);
        return {8'h00, (set ? FLAG_SET : FLAG_CLR)};
    endfunction

endpackage

// File: rtl/ca_attn_edge.sv
module ca_attn_edge (
    input  logic clk,
    input  logic rst,
    input  logic attn_n,
    input  logic sel,
    output logic evt,
    output logic evt_sel
);
    logic attn_prev;

    always_ff @(posedge clk) begin
        if (rst) attn_prev <= 1'b1;
        else     attn_prev <= attn_n;
    end

    assign evt     = attn_prev & ~attn_n;
    assign evt_sel = sel;
endmodule

// File: rtl/ca_chan_ctx.sv
module ca_chan_ctx
    import chan_attn_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          attn_evt,
    input  logic          attn_sel,
    input  logic          ld_cmd,
    input  logic          ld_pbl,
    input  logic          ld_pbh,
    input  logic          ld_pa0,
    input  logic          ld_pa1,
    input  logic          go,
    input  logic          clr_ok,
    input  logic [DW-1:0] rdata,
    input  logic          done,
    input  logic          halt,
    input  logic          irq_ack,
    output logic          attn_pend,
    output logic          fin_pend,
    output cmd_t          cmd,
    output logic [AW-1:0] pb_addr,
    output logic [AW-1:0] prog_addr,
    output logic          irq,
    output logic          err
);
    localparam logic MY_SEL = (CH != 0);

    logic busy;
    logic running;
    logic hit;

    assign hit = attn_evt && (attn_sel == MY_SEL);

    // ownership of the channel: from accepted strobe until clear write done
    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            attn_pend <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (hit && busy)       err <= 1'b1;
            if (hit && !busy) begin
                busy      <= 1'b1;
                attn_pend <= 1'b1;
            end
            if (ld_cmd)            attn_pend <= 1'b0;
            if (clr_ok)            busy      <= 1'b0;
        end
    end

    // latched control-block contents and start address
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            pb_addr   <= '0;
            prog_addr <= '0;
        end else begin
            if (ld_cmd) cmd <= cmd_t'(rdata[CMD_W-1:0]);
            if (ld_pbl) pb_addr[DW-1:0]  <= rdata;
            if (ld_pbh) pb_addr[AW-1:DW] <= rdata[HI_W-1:0];
            if (ld_pa0) prog_addr        <= {{HI_W{1'b0}}, rdata};
            if (ld_pa1) prog_addr[AW-1:DW] <= rdata[HI_W-1:0];
        end
    end

    // engine run state and finish request
    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            fin_pend <= 1'b0;
        end else begin
            if (go) running <= 1'b1;
            if (running && (done || halt)) begin
                running  <= 1'b0;
                fin_pend <= 1'b1;
            end
            if (clr_ok) fin_pend <= 1'b0;
        end
    end

    // interrupt: acknowledge wins over a same-cycle set
    always_ff @(posedge clk) begin
        if (rst)                irq <= 1'b0;
        else if (irq_ack)       irq <= 1'b0;
        else if (clr_ok && cmd.ie) irq <= 1'b1;
    end
endmodule

// File: rtl/ca_seq.sv
module ca_seq
    import chan_attn_pkg::*;
#(
    parameter logic [AW-1:0] CB_BASE   = 20'h00100,
    parameter logic [AW-1:0] CB_STRIDE = 20'h00010
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          attn_pend,
    input  logic [NCH-1:0]          fin_pend,
    input  logic [NCH-1:0]          space_io,
    input  logic [NCH-1:0][AW-1:0]  pb_addr,
    input  logic                    mem_ack,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [1:0]              mem_be,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    output logic [NCH-1:0]          ld_cmd,
    output logic [NCH-1:0]          ld_pbl,
    output logic [NCH-1:0]          ld_pbh,
    output logic [NCH-1:0]          ld_pa0,
    output logic [NCH-1:0]          ld_pa1,
    output logic [NCH-1:0]          go,
    output logic [NCH-1:0]          clr_ok
);
    seq_t            state;
    logic            cur;
    logic [NCH-1:0]  cur_vec;
    logic [AW-1:0]   base;

    assign cur_vec = cur ? 2'b10 : 2'b01;
    assign base    = chan_base(CB_BASE, CB_STRIDE, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (fin_pend[0]) begin
                        cur <= 1'b0; state <= S_CLR;
                    end else if (fin_pend[1]) begin
                        cur <= 1'b1; state <= S_CLR;
                    end else if (attn_pend[0]) begin
                        cur <= 1'b0; state <= S_CMD;
                    end else if (attn_pend[1]) begin
                        cur <= 1'b1; state <= S_CMD;
                    end
                end
                S_CMD: if (mem_ack) state <= S_PBL;
                S_PBL: if (mem_ack) state <= S_PBH;
                S_PBH: if (mem_ack) state <= S_SET;
                S_SET: if (mem_ack) state <= S_PA0;
                S_PA0: if (mem_ack) state <= space_io[cur] ? S_GO : S_PA1;
                S_PA1: if (mem_ack) state <= S_GO;
                S_GO:  state <= S_IDLE;
                S_CLR: if (mem_ack) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = BE_WORD;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_CMD: begin mem_req = 1'b1; mem_addr = base + OFS_CMD; end
            S_PBL: begin mem_req = 1'b1; mem_addr = base + OFS_PBL; end
            S_PBH: begin mem_req = 1'b1; mem_addr = base + OFS_PBH; end
            S_SET: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_be = BE_LOW;
                mem_addr = base + OFS_FLAG; mem_wdata = flag_word(1'b1);
            end
            S_PA0: begin mem_req = 1'b1; mem_addr = pb_addr[cur]; end
            S_PA1: begin mem_req = 1'b1; mem_addr = pb_addr[cur] + WORD_STEP; end
            S_CLR: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_be = BE_LOW;
                mem_addr = base + OFS_FLAG; mem_wdata = flag_word(1'b0);
            end
            default: ;
        endcase
    end

    assign ld_cmd = (state == S_CMD && mem_ack) ? cur_vec : '0;
    assign ld_pbl = (state == S_PBL && mem_ack) ? cur_vec : '0;
    assign ld_pbh = (state == S_PBH && mem_ack) ? cur_vec : '0;
    assign ld_pa0 = (state == S_PA0 && mem_ack) ? cur_vec : '0;
    assign ld_pa1 = (state == S_PA1 && mem_ack) ? cur_vec : '0;
    assign go     = (state == S_GO)             ? cur_vec : '0;
    assign clr_ok = (state == S_CLR && mem_ack) ? cur_vec : '0;
endmodule

// File: rtl/chan_attn_ctrl.sv
module chan_attn_ctrl
    import chan_attn_pkg::*;
#(
    parameter logic [AW-1:0] CB_BASE   = 20'h00100,
    parameter logic [AW-1:0] CB_STRIDE = 20'h00010
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       attn_n_i,
    input  logic                       sel_i,
    input  logic [NCH-1:0]             done_i,
    input  logic [NCH-1:0]             halt_i,
    input  logic [NCH-1:0]             irq_ack_i,
    output logic                       mem_req_o,
    output logic                       mem_we_o,
    output logic [1:0]                 mem_be_o,
    output logic [AW-1:0]              mem_addr_o,
    output logic [DW-1:0]              mem_wdata_o,
    input  logic                       mem_ack_i,
    input  logic [DW-1:0]              mem_rdata_i,
    output logic [NCH-1:0]             eng_start_o,
    output logic [NCH-1:0][CODE_W-1:0] eng_cmd_o,
    output logic [NCH-1:0][PRIO_W-1:0] eng_prio_o,
    output logic [NCH-1:0][AW-1:0]     eng_pb_addr_o,
    output logic [NCH-1:0][AW-1:0]     eng_prog_addr_o,
    output logic [NCH-1:0]             irq_o,
    output logic [NCH-1:0]             err_o
);
    logic                   evt, evt_sel;
    logic [NCH-1:0]         attn_pend, fin_pend, space_io;
    logic [NCH-1:0]         ld_cmd, ld_pbl, ld_pbh, ld_pa0, ld_pa1, go, clr_ok;
    logic [NCH-1:0][AW-1:0] pb_addr;
    cmd_t                   cmd [NCH];

    ca_attn_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .attn_n  (attn_n_i),
        .sel     (sel_i),
        .evt     (evt),
        .evt_sel (evt_sel)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ca_chan_ctx #(.CH(c)) u_ctx (
            .clk       (clk),
            .rst       (rst),
            .attn_evt  (evt),
            .attn_sel  (evt_sel),
            .ld_cmd    (ld_cmd[c]),
            .ld_pbl    (ld_pbl[c]),
            .ld_pbh    (ld_pbh[c]),
            .ld_pa0    (ld_pa0[c]),
            .ld_pa1    (ld_pa1[c]),
            .go        (go[c]),
            .clr_ok    (clr_ok[c]),
            .rdata     (mem_rdata_i),
            .done      (done_i[c]),
            .halt      (halt_i[c]),
            .irq_ack   (irq_ack_i[c]),
            .attn_pend (attn_pend[c]),
            .fin_pend  (fin_pend[c]),
            .cmd       (cmd[c]),
            .pb_addr   (pb_addr[c]),
            .prog_addr (eng_prog_addr_o[c]),
            .irq       (irq_o[c]),
            .err       (err_o[c])
        );
        assign space_io[c]      = cmd[c].space_io;
        assign eng_cmd_o[c]     = cmd[c].code;
        assign eng_prio_o[c]    = cmd[c].prio;
        assign eng_pb_addr_o[c] = pb_addr[c];
    end

    ca_seq #(.CB_BASE(CB_BASE), .CB_STRIDE(CB_STRIDE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .attn_pend (attn_pend),
        .fin_pend  (fin_pend),
        .space_io  (space_io),
        .pb_addr   (pb_addr),
        .mem_ack   (mem_ack_i),
        .mem_req   (mem_req_o),
        .mem_we    (mem_we_o),
        .mem_be    (mem_be_o),
        .mem_addr  (mem_addr_o),
        .mem_wdata (mem_wdata_o),
        .ld_cmd    (ld_cmd),
        .ld_pbl    (ld_pbl),
        .ld_pbh    (ld_pbh),
        .ld_pa0    (ld_pa0),
        .ld_pa1    (ld_pa1),
        .go        (go),
        .clr_ok    (clr_ok)
    );

    assign eng_start_o = go;
endmodule

// File: rtl/chan_attn_chk.sv
module chan_attn_chk
    import chan_attn_pkg::*;
#(
    parameter logic [AW-1:0] CB_BASE   = 20'h00100,
    parameter logic [AW-1:0] CB_STRIDE = 20'h00010
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    irq_ack_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [1:0]        mem_be_o,
    input logic [AW-1:0]     mem_addr_o,
    input logic [DW-1:0]     mem_wdata_o,
    input logic              mem_ack_i,
    input logic [NCH-1:0]    eng_start_o,
    input logic [NCH-1:0]    irq_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)); // R10

    AST_WRITE_FORM: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o |-> mem_be_o == BE_LOW
            && (mem_wdata_o == 16'h00FF || mem_wdata_o == 16'h0000)); // R3

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eng_start_o)); // R5

    for (genvar c = 0; c < NCH; c++) begin : g_ck
        localparam logic [AW-1:0] FLAG_AT =
            chan_base(CB_BASE, CB_STRIDE, c != 0) + OFS_FLAG;

        AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
            eng_start_o[c] |=> !eng_start_o[c]); // R5

        AST_IRQ_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[c]) |-> $past(mem_req_o && mem_ack_i && mem_we_o
                && mem_addr_o == FLAG_AT && mem_wdata_o[7:0] == FLAG_CLR)); // R8

        AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] && !irq_ack_i[c] |=> irq_o[c]); // R8

        AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
            irq_ack_i[c] |=> !irq_o[c]); // R8
    end
endmodule

bind chan_attn_ctrl chan_attn_chk #(.CB_BASE(CB_BASE), .CB_STRIDE(CB_STRIDE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_ack_i   (irq_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_be_o    (mem_be_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .eng_start_o (eng_start_o),
    .irq_o       (irq_o)
);

// File: tb/tb_chan_attn_ctrl.sv
module tb_chan_attn_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic attn_n = 1'b1, sel = 1'b0;
    logic [1:0] done = '0, halt = '0, irq_ack = '0;
    logic mem_req, mem_we, mem_ack;
    logic [1:0] mem_be;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0] eng_start, irq, err;
    logic [1:0][2:0] eng_cmd;
    logic [1:0][1:0] eng_prio;
    logic [1:0][19:0] eng_pb, eng_prog;

    chan_attn_ctrl dut (
        .clk(clk), .rst(rst), .attn_n_i(attn_n), .sel_i(sel),
        .done_i(done), .halt_i(halt), .irq_ack_i(irq_ack),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_be_o(mem_be),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .eng_start_o(eng_start), .eng_cmd_o(eng_cmd), .eng_prio_o(eng_prio),
        .eng_pb_addr_o(eng_pb), .eng_prog_addr_o(eng_prog),
        .irq_o(irq), .err_o(err)
    );

    // shared memory model with access log
    logic [15:0] mem_w [0:255];
    logic [19:0] log_addr [0:31];
    logic        log_we   [0:31];
    int          log_n;
    logic        hw_en = 1'b0, log_clr = 1'b0;
    logic [19:0] hw_addr = '0;
    logic [15:0] hw_data = '0;

    assign mem_rdata = mem_w[mem_addr[8:1]];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            log_n   <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                if (log_n < 32) begin
                    log_addr[log_n] <= mem_addr;
                    log_we[log_n]   <= mem_we;
                end
                log_n <= log_n + 1;
                if (mem_we) begin
                    if (mem_be[0]) mem_w[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
                    if (mem_be[1]) mem_w[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
                end
            end
            if (log_clr) log_n <= 0;
        end
        if (hw_en) mem_w[hw_addr[8:1]] <= hw_data;
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk); hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk); hw_en = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic strobe(input logic ch);
        @(negedge clk); sel = ch; attn_n = 1'b0;
        @(negedge clk);
        @(negedge clk); attn_n = 1'b1;
    endtask

    task automatic wait_start(input int ch, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (eng_start[ch]) seen = 1'b1;
        end
    endtask

    task automatic wait_flag(input logic [19:0] a, input logic [7:0] v);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_w[a[8:1]][7:0] == v) break;
        end
    endtask

    task automatic pulse_fin(input int ch, input bit is_halt);
        @(negedge clk);
        if (is_halt) halt[ch] = 1'b1; else done[ch] = 1'b1;
        @(negedge clk); halt = '0; done = '0;
    endtask

    task automatic chk_log(input int idx, input logic [19:0] a, input logic we, input string req);
        chk(log_addr[idx] == a && log_we[idx] == we, req, {11'h0, we, log_addr[idx]}, {11'h0, we, a});
    endtask

    task automatic t_reset();
        chk(mem_req == 1'b0, "R1 req", mem_req, 0);
        chk(eng_start == 2'b00, "R1 start", eng_start, 0);
        chk(irq == 2'b00, "R1 irq", irq, 0);
        chk(err == 2'b00, "R1 err", err, 0);
    endtask

    // channel 0, system space, interrupt on, done
    task automatic t_ch0_system();
        bit seen;
        put(20'h00100, 16'h002D);   // code 5, ie 1, prio 2, system space
        put(20'h00102, 16'h0040);
        put(20'h00104, 16'h0000);
        put(20'h00106, 16'h0000);
        put(20'h00040, 16'h1234);
        put(20'h00042, 16'h0005);
        clear_log();
        strobe(1'b0);
        wait_start(0, seen);
        chk(seen, "R5 start ch0", seen, 1);
        chk(log_n == 6, "R4 system count", log_n, 6);
        chk_log(0, 20'h00100, 1'b0, "R2 cmd read");
        chk_log(1, 20'h00102, 1'b0, "R2 pbl read");
        chk_log(2, 20'h00104, 1'b0, "R2 pbh read");
        chk_log(3, 20'h00106, 1'b1, "R3 flag set write");
        chk_log(4, 20'h00040, 1'b0, "R4 pa0 read");
        chk_log(5, 20'h00042, 1'b0, "R4 pa1 read");
        chk(mem_w[8'h83] == 16'h00FF, "R3 flag value", mem_w[8'h83], 16'h00FF);
        chk(eng_cmd[0] == 3'd5, "R5 code", eng_cmd[0], 5);
        chk(eng_prog[0] == 20'h51234, "R4 prog addr", eng_prog[0], 20'h51234);
        chk(eng_pb[0] == 20'h00040, "R5 pb addr", eng_pb[0], 20'h40);
        chk(eng_prio[0] == 2'd2, "R6 prio ch0", eng_prio[0], 2);
        chk(irq[0] == 1'b0, "R8 no early irq", irq[0], 0);
        // busy violation
        clear_log();
        strobe(1'b0);
        repeat (10) @(negedge clk);
        chk(log_n == 0, "R9 no access", log_n, 0);
        chk(err == 2'b01, "R9 err ch0", err, 2'b01);
        pulse_fin(0, 1'b0);
        for (int i = 0; i < 50 && !irq[0]; i++) @(negedge clk);
        chk(mem_w[8'h83][7:0] == 8'h00, "R7 flag cleared", mem_w[8'h83], 0);
        chk(irq[0] == 1'b1, "R8 irq raised", irq[0], 1);
        chk(log_we[log_n-1] == 1'b1 && log_addr[log_n-1] == 20'h00106, "R8 irq after clear",
            log_addr[log_n-1], 20'h00106);
        repeat (3) @(negedge clk);
        chk(irq[0] == 1'b1, "R8 irq held", irq[0], 1);
        irq_ack[0] = 1'b1;
        @(negedge clk); irq_ack = '0;
        chk(irq[0] == 1'b0, "R8 irq acked", irq[0], 0);
    endtask

    // channel 1, I/O space, no interrupt, halt
    task automatic t_ch1_io();
        bit seen;
        put(20'h00110, 16'h0053);   // code 3, ie 0, prio 1, I/O space
        put(20'h00112, 16'h0060);
        put(20'h00114, 16'h0000);
        put(20'h00116, 16'h0000);
        put(20'h00060, 16'hBEEF);
        clear_log();
        strobe(1'b1);
        wait_start(1, seen);
        chk(seen, "R5 start ch1", seen, 1);
        chk(log_n == 5, "R4 io count", log_n, 5);
        chk_log(3, 20'h00116, 1'b1, "R3 flag set ch1");
        chk_log(4, 20'h00060, 1'b0, "R4 io read");
        chk(eng_prog[1] == 20'h0BEEF, "R4 io prog", eng_prog[1], 20'h0BEEF);
        chk(eng_cmd[1] == 3'd3, "R5 code ch1", eng_cmd[1], 3);
        chk(eng_prio[1] == 2'd1, "R6 prio ch1", eng_prio[1], 1);
        chk(mem_w[8'h8B] == 16'h00FF, "R3 flag ch1", mem_w[8'h8B], 16'h00FF);
        pulse_fin(1, 1'b1);
        wait_flag(20'h00116, 8'h00);
        repeat (4) @(negedge clk);
        chk(mem_w[8'h8B][7:0] == 8'h00, "R7 halt clears", mem_w[8'h8B], 0);
        chk(irq == 2'b00, "R8 no irq when disabled", irq, 0);
        chk(err == 2'b01, "R9 err sticky", err, 2'b01);
    endtask

    // both channels: service order
    task automatic t_order();
        bit s0, s1;
        put(20'h00100, 16'h0041);   // ch0: I/O space, code 1, ie 0
        clear_log();
        strobe(1'b0);
        strobe(1'b1);
        wait_start(0, s0);
        wait_start(1, s1);
        chk(s0 && s1, "R11 both started", {s0, s1}, 2'b11);
        chk_log(5, 20'h00110, 1'b0, "R11 ch1 after ch0");
        clear_log();
        @(negedge clk); done = 2'b11;
        @(negedge clk); done = 2'b00;
        wait_flag(20'h00116, 8'h00);
        repeat (3) @(negedge clk);
        chk(log_n == 2, "R11 two clears", log_n, 2);
        chk_log(0, 20'h00106, 1'b1, "R11 ch0 clear first");
        chk_log(1, 20'h00116, 1'b1, "R11 ch1 clear second");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_ch0_system();
        t_ch1_io();
        t_order();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule